// File: doc/BRIEF.md
# Flash Busy-Bank Status Flag Generator

This block sits beside the command decoder of a NOR flash and produces three status bits that a host sees when it reads a bank while that bank is busy with an internal program or erase. The first is a toggle bit that inverts on every qualifying read while an operation runs. The second is a failure bit that latches when the internal algorithm reports that its pulse budget ran out. The third is an erase-window bit. It stays low while more sector-erase commands may still be queued and goes high once the erase itself has started.

The decoder delivers one-cycle command pulses. The internal algorithm reports completion or overrun. The host read strobes (active-low chip enable and output enable) arrive asynchronously and are synchronised inside the block. When every targeted sector is protected, a timer stands in for the algorithm: it runs a fixed-length dummy busy period and then drops the block back to idle. The same timer measures the sector-erase acceptance window.

The controller is a state machine with ten states:
- ST_IDLE: no operation is running.
- ST_PROG: a program is running.
- ST_PROG_DUMMY: a program aimed at a protected sector is running its dummy period.
- ST_ERASE_WIN: the sector-erase window is open.
- ST_ERASE_RUN: an erase is running.
- ST_ERASE_DUMMY: an erase in which every target is protected is running its dummy period.
- ST_SUSPENDED: an erase is suspended.
- ST_SUSP_PROG: a program issued during suspend is running.
- ST_SUSP_DUMMY: a protected program issued during suspend is running its dummy period.
- ST_FAILED: the pulse budget was exceeded.

The transitions are:
- From idle, a program goes to prog or prog-dummy, a chip erase goes to erase-run or erase-dummy, and a sector erase goes to the window.
- In the window, another sector erase restarts the window. When the window timer expires, the block goes to erase-run, or to erase-dummy if every selected sector was protected.
- Erase-run goes to suspended on suspend. Suspended goes back to erase-run on resume, and goes to susp-prog or susp-dummy on a program.
- Completion returns prog and erase-run to idle, and returns susp-prog to suspended.
- Expiry of a dummy timer returns prog-dummy and erase-dummy to idle, and returns susp-dummy to suspended.
- An overrun in prog, erase-run or susp-prog goes to failed.
- A reset command leads from every state to idle.

Top module: `flash_status_flags`

## Requirements
- R1: After rst_n is released, toggle_bit, limit_bit and window_bit are all 0.
- R2: A read is the falling edge of the combined strobe (ce_n OR oe_n). It passes through a two-stage synchroniser and is qualified by bank_hit. While an operation is busy, each read inverts toggle_bit on the third rising clock edge after the strobe falls. The busy states are prog, prog-dummy, window, erase-run, erase-dummy, susp-prog, susp-dummy and failed.
- R3: A read with bank_hit=0, or any read in idle or suspended, leaves toggle_bit unchanged. After completion, toggle_bit holds its value.
- R4: A program with tgt_protected=1 keeps the block busy for PROG_DUMMY_CYC cycles without the algorithm, then returns to idle. Reads toggle during that period and not after it.
- R5: A chip erase with tgt_protected=1 (meaning every sector is protected) sets window_bit=1 for exactly ERASE_DUMMY_CYC cycles and then returns to idle with window_bit=0.
- R6: A sector erase opens the window. window_bit reads 0 and reads toggle. Each further sector erase in the window restarts it. window_bit rises exactly WIN_CYC cycles after the last accepted sector-erase command.
- R7: At the end of the window, the block enters erase-run if any sector erased during the window had tgt_protected=0. Otherwise it runs an ERASE_DUMMY_CYC dummy period. In both cases window_bit reads 1.
- R8: A sector-erase command while window_bit=1 is ignored. window_bit stays 1 and reads keep toggling.
- R9: Suspend stops toggling and keeps window_bit=1. A program issued during suspend toggles again, and its completion returns to suspended. Resume restarts toggling. Completion of the erase clears window_bit.
- R10: alg_timeout in prog, erase-run or susp-prog sets limit_bit=1. alg_timeout takes priority over a simultaneous alg_done. limit_bit holds and reads keep toggling until a reset command.
- R11: cmd_reset returns every state to idle. limit_bit and window_bit are 0 on the next cycle, later reads do not toggle, and a window that was open never completes.
- R12: A read whose qualified event falls in the same cycle as the completion pulse still inverts toggle_bit once. The state before that edge decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prog | input | 1 | Program command accepted (pulse) |
| cmd_sect_erase | input | 1 | Sector-erase command accepted (pulse) |
| cmd_chip_erase | input | 1 | Chip-erase command accepted (pulse) |
| cmd_suspend | input | 1 | Erase suspend (pulse) |
| cmd_resume | input | 1 | Erase resume (pulse) |
| cmd_reset | input | 1 | Reset command sequence (pulse) |
| tgt_protected | input | 1 | Target sector protected, valid with a command pulse |
| alg_done | input | 1 | Internal algorithm finished (pulse) |
| alg_timeout | input | 1 | Internal pulse budget exceeded (pulse) |
| ce_n | input | 1 | Host chip enable, active low, asynchronous |
| oe_n | input | 1 | Host output enable, active low, asynchronous |
| bank_hit | input | 1 | Read address lies in the busy bank |
| toggle_bit | output | 1 | Inverting busy indicator |
| limit_bit | output | 1 | Timing limit exceeded |
| window_bit | output | 1 | 0 while the erase window is open, 1 once the erase has started |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a synchronised read event and the completion pulse. The bench provokes this by raising alg_done exactly in the cycle in which the third edge after the strobe falls. It then expects one inversion and no inversion on the next read. The second pair is alg_done and alg_timeout in the same cycle. Here the bench expects limit_bit to set, which it judges through the failure bit staying high and the toggling continuing.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_PROG_DUMMY,
        ST_ERASE_WIN,
        ST_ERASE_RUN,
        ST_ERASE_DUMMY,
        ST_SUSPENDED,
        ST_SUSP_PROG,
        ST_SUSP_DUMMY,
        ST_FAILED
    } fsf_state_e;

    // States in which a qualified read inverts the toggle flag
    function automatic logic is_busy(fsf_state_e s);
        return !(s == ST_IDLE || s == ST_SUSPENDED);
    endfunction

    // States in which the erase has been committed (window closed)
    function automatic logic is_committed(fsf_state_e s);
        return (s == ST_ERASE_RUN) || (s == ST_ERASE_DUMMY) ||
               (s == ST_SUSPENDED) || (s == ST_SUSP_PROG) ||
               (s == ST_SUSP_DUMMY);
    endfunction

endpackage

// File: rtl/fsf_read_detect.sv
module fsf_read_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic bank_hit,
    output logic rd_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= ce_n | oe_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rd_evt = prev_q & ~sync_q[SYNC_STAGES-1] & bank_hit;

endmodule

// File: rtl/fsf_timer.sv
module fsf_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             abort,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (abort) begin
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= len - CNT_W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = run_q && (cnt_q == '0);

    // R6: an expiry is a single-cycle event unless the window is restarted
    p_expire_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !load |=> !expire);

endmodule

// File: rtl/fsf_ctrl.sv
module fsf_ctrl
    import fsf_pkg::*;
#(
    parameter int unsigned CNT_W           = 8,
    parameter int unsigned PROG_DUMMY_CYC  = 50,
    parameter int unsigned ERASE_DUMMY_CYC = 200,
    parameter int unsigned WIN_CYC         = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_prog,
    input  logic             cmd_sect_erase,
    input  logic             cmd_chip_erase,
    input  logic             cmd_suspend,
    input  logic             cmd_resume,
    input  logic             cmd_reset,
    input  logic             tgt_protected,
    input  logic             alg_done,
    input  logic             alg_timeout,
    input  logic             tmr_expire,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_len,
    output logic             tmr_abort,
    output fsf_state_e       state,
    output logic             limit_bit,
    output logic             window_bit
);
    localparam logic [CNT_W-1:0] LEN_PD = CNT_W'(PROG_DUMMY_CYC);
    localparam logic [CNT_W-1:0] LEN_ED = CNT_W'(ERASE_DUMMY_CYC);
    localparam logic [CNT_W-1:0] LEN_WN = CNT_W'(WIN_CYC);

    fsf_state_e st_q, st_d;
    logic       unprot_q, unprot_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            unprot_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            unprot_q <= unprot_d;
        end
    end

    // Next-state and timer-load decision
    always_comb begin
        st_d     = st_q;
        unprot_d = unprot_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        if (cmd_reset) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd_prog) begin
                        if (tgt_protected) begin
                            st_d     = ST_PROG_DUMMY;
                            tmr_load = 1'b1;
                            tmr_len  = LEN_PD;
                        end else begin
                            st_d = ST_PROG;
                        end
                    end else if (cmd_chip_erase) begin
                        if (tgt_protected) begin
                            st_d     = ST_ERASE_DUMMY;
                            tmr_load = 1'b1;
                            tmr_len  = LEN_ED;
                        end else begin
                            st_d = ST_ERASE_RUN;
                        end
                    end else if (cmd_sect_erase) begin
                        st_d     = ST_ERASE_WIN;
                        tmr_load = 1'b1;
                        tmr_len  = LEN_WN;
                        unprot_d = !tgt_protected;
                    end
                end
                ST_PROG: begin
                    if (alg_timeout)   st_d = ST_FAILED;
                    else if (alg_done) st_d = ST_IDLE;
                end
                ST_PROG_DUMMY: begin
                    if (tmr_expire) st_d = ST_IDLE;
                end
                ST_ERASE_WIN: begin
                    if (cmd_sect_erase) begin
                        tmr_load = 1'b1;
                        tmr_len  = LEN_WN;
                        unprot_d = unprot_q | !tgt_protected;
                    end else if (tmr_expire) begin
                        if (unprot_q) begin
                            st_d = ST_ERASE_RUN;
                        end else begin
                            st_d     = ST_ERASE_DUMMY;
                            tmr_load = 1'b1;
                            tmr_len  = LEN_ED;
                        end
                    end
                end
                ST_ERASE_RUN: begin
                    if (alg_timeout)      st_d = ST_FAILED;
                    else if (alg_done)    st_d = ST_IDLE;
                    else if (cmd_suspend) st_d = ST_SUSPENDED;
                end
                ST_ERASE_DUMMY: begin
                    if (tmr_expire) st_d = ST_IDLE;
                end
                ST_SUSPENDED: begin
                    if (cmd_resume) begin
                        st_d = ST_ERASE_RUN;
                    end else if (cmd_prog) begin
                        if (tgt_protected) begin
                            st_d     = ST_SUSP_DUMMY;
                            tmr_load = 1'b1;
                            tmr_len  = LEN_PD;
                        end else begin
                            st_d = ST_SUSP_PROG;
                        end
                    end
                end
                ST_SUSP_PROG: begin
                    if (alg_timeout)   st_d = ST_FAILED;
                    else if (alg_done) st_d = ST_SUSPENDED;
                end
                ST_SUSP_DUMMY: begin
                    if (tmr_expire) st_d = ST_SUSPENDED;
                end
                ST_FAILED: begin
                    st_d = ST_FAILED;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        state      = st_q;
        tmr_abort  = cmd_reset;
        limit_bit  = (st_q == ST_FAILED);
        window_bit = is_committed(st_q);
    end

    // R10: the failure flag only rises after an overrun report
    p_limit_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(limit_bit) |-> $past(alg_timeout));

    // R10: the failure flag holds until a reset command
    p_limit_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        limit_bit && !cmd_reset |=> limit_bit);

    // R8: a sector erase after the window closed does not reopen it
    p_window_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        window_bit && cmd_sect_erase && !cmd_reset && !alg_done &&
        !alg_timeout && !tmr_expire |=> window_bit);

    // R11: a reset command clears both flags on the next cycle
    p_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !limit_bit && !window_bit);

endmodule

// File: rtl/fsf_toggle.sv
module fsf_toggle
    import fsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_evt,
    input  fsf_state_e state,
    output logic       toggle_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          toggle_bit <= 1'b0;
        else if (rd_evt && is_busy(state))   toggle_bit <= ~toggle_bit;
    end
endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
    import fsf_pkg::*;
#(
    parameter int unsigned PROG_DUMMY_CYC  = 50,
    parameter int unsigned ERASE_DUMMY_CYC = 20000,
    parameter int unsigned WIN_CYC         = 2500,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_prog,
    input  logic cmd_sect_erase,
    input  logic cmd_chip_erase,
    input  logic cmd_suspend,
    input  logic cmd_resume,
    input  logic cmd_reset,
    input  logic tgt_protected,
    input  logic alg_done,
    input  logic alg_timeout,
    input  logic ce_n,
    input  logic oe_n,
    input  logic bank_hit,
    output logic toggle_bit,
    output logic limit_bit,
    output logic window_bit
);
    localparam int unsigned MAX_A = (PROG_DUMMY_CYC > ERASE_DUMMY_CYC) ?
                                    PROG_DUMMY_CYC : ERASE_DUMMY_CYC;
    localparam int unsigned MAX_L = (MAX_A > WIN_CYC) ? MAX_A : WIN_CYC;
    localparam int unsigned CNT_W = $clog2(MAX_L + 1);

    logic             rd_evt;
    logic             tmr_load;
    logic             tmr_abort;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_len;
    fsf_state_e       state;

    fsf_read_detect #(.SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .bank_hit (bank_hit),
        .rd_evt   (rd_evt)
    );

    fsf_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .abort  (tmr_abort),
        .expire (tmr_expire)
    );

    fsf_ctrl #(
        .CNT_W           (CNT_W),
        .PROG_DUMMY_CYC  (PROG_DUMMY_CYC),
        .ERASE_DUMMY_CYC (ERASE_DUMMY_CYC),
        .WIN_CYC         (WIN_CYC)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_prog       (cmd_prog),
        .cmd_sect_erase (cmd_sect_erase),
        .cmd_chip_erase (cmd_chip_erase),
        .cmd_suspend    (cmd_suspend),
        .cmd_resume     (cmd_resume),
        .cmd_reset      (cmd_reset),
        .tgt_protected  (tgt_protected),
        .alg_done       (alg_done),
        .alg_timeout    (alg_timeout),
        .tmr_expire     (tmr_expire),
        .tmr_load       (tmr_load),
        .tmr_len        (tmr_len),
        .tmr_abort      (tmr_abort),
        .state          (state),
        .limit_bit      (limit_bit),
        .window_bit     (window_bit)
    );

    fsf_toggle u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt     (rd_evt),
        .state      (state),
        .toggle_bit (toggle_bit)
    );

    // R2: the toggle flag never moves without a synchronised read event
    p_toggle_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_evt |=> $stable(toggle_bit));

endmodule

// File: tb/sim_flash_status_flags.sv
module sim_flash_status_flags;
    localparam int unsigned PD = 30;
    localparam int unsigned ED = 30;
    localparam int unsigned WN = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_prog = 0, cmd_sect_erase = 0, cmd_chip_erase = 0;
    logic cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0;
    logic tgt_protected = 0, alg_done = 0, alg_timeout = 0;
    logic ce_n = 1, oe_n = 1, bank_hit = 0;
    logic toggle_bit, limit_bit, window_bit;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    logic exp_tog = 1'b0;

    always #10 clk = ~clk;

    flash_status_flags #(
        .PROG_DUMMY_CYC (PD),
        .ERASE_DUMMY_CYC(ED),
        .WIN_CYC        (WN),
        .SYNC_STAGES    (2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .tgt_protected(tgt_protected), .alg_done(alg_done),
        .alg_timeout(alg_timeout), .ce_n(ce_n), .oe_n(oe_n),
        .bank_hit(bank_hit), .toggle_bit(toggle_bit),
        .limit_bit(limit_bit), .window_bit(window_bit)
    );

    function automatic logic next_tog(logic cur, logic busy, logic hit);
        return cur ^ (busy & hit);
    endfunction

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // mask bits: 0 prog, 1 sect, 2 chip, 3 suspend, 4 resume, 5 reset, 6 done, 7 timeout
    task automatic issue(input logic [7:0] m, input logic prot);
        @(negedge clk);
        cmd_prog = m[0]; cmd_sect_erase = m[1]; cmd_chip_erase = m[2];
        cmd_suspend = m[3]; cmd_resume = m[4]; cmd_reset = m[5];
        alg_done = m[6]; alg_timeout = m[7]; tgt_protected = prot;
        @(negedge clk);
        {cmd_prog, cmd_sect_erase, cmd_chip_erase, cmd_suspend, cmd_resume,
         cmd_reset, alg_done, alg_timeout, tgt_protected} = '0;
    endtask

    // mode 0: both strobes together, 1: chip enable pulses, 2: output enable pulses
    task automatic do_read(input logic hit, input int mode, input logic busy);
        @(negedge clk);
        bank_hit = hit;
        if (mode == 1) oe_n = 1'b0;
        if (mode == 2) ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        wait_cyc(4);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_cyc(4);
        bank_hit = 1'b0;
        exp_tog = next_tog(exp_tog, busy, hit);
    endtask

    task automatic read_chk(input logic hit, input logic busy, input string req, input string what);
        do_read(hit, 0, busy);
        chk(toggle_bit, exp_tog, req, what);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_set;
        seed_set = $urandom(32'h5eed);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1
        chk(toggle_bit, 1'b0, "R1", "toggle after reset");
        chk(limit_bit, 1'b0, "R1", "limit after reset");
        chk(window_bit, 1'b0, "R1", "window after reset");

        // R3: idle reads do nothing
        read_chk(1'b1, 1'b0, "R3", "idle read");

        // R2 / R3: program, directed then random reads
        issue(8'h01, 1'b0);
        read_chk(1'b1, 1'b1, "R2", "program read");
        read_chk(1'b0, 1'b1, "R3", "program read other bank");
        for (int i = 0; i < 30; i++) begin
            logic h;
            int   md;
            h  = 1'($urandom_range(0, 1));
            md = int'($urandom_range(0, 2));
            do_read(h, md, 1'b1);
            chk(toggle_bit, exp_tog, "R2", "random program read");
        end
        issue(8'h40, 1'b0);
        read_chk(1'b1, 1'b0, "R3", "read after program done");
        read_chk(1'b1, 1'b0, "R3", "second read after done");

        // R12: read event and completion on the same edge
        issue(8'h01, 1'b0);
        @(negedge clk);
        bank_hit = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        alg_done = 1'b1;
        @(negedge clk);
        alg_done = 1'b0;
        exp_tog = ~exp_tog;
        chk(toggle_bit, exp_tog, "R12", "read coinciding with done");
        wait_cyc(2);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_cyc(4);
        bank_hit = 1'b0;
        read_chk(1'b1, 1'b0, "R12", "read after coinciding done");

        // R4: protected program dummy period
        issue(8'h01, 1'b1);
        read_chk(1'b1, 1'b1, "R4", "read in program dummy");
        wait_cyc(PD + 5);
        read_chk(1'b1, 1'b0, "R4", "read after program dummy");

        // R5: chip erase, all protected; exact window_bit timing
        issue(8'h04, 1'b1);
        chk(window_bit, 1'b1, "R5", "window at dummy start");
        wait_cyc(ED - 1);
        chk(window_bit, 1'b1, "R5", "window last dummy cycle");
        wait_cyc(1);
        chk(window_bit, 1'b0, "R5", "window after dummy");

        // R6 / R7 / R8 / R9: sector erase flow
        issue(8'h02, 1'b0);
        chk(window_bit, 1'b0, "R6", "window open");
        read_chk(1'b1, 1'b1, "R6", "read in window");
        issue(8'h02, 1'b1);
        wait_cyc(WN - 1);
        chk(window_bit, 1'b0, "R6", "restarted window still open");
        wait_cyc(1);
        chk(window_bit, 1'b1, "R6", "window closes on time");
        read_chk(1'b1, 1'b1, "R7", "read in erase run");
        issue(8'h02, 1'b0);
        chk(window_bit, 1'b1, "R8", "late sector erase ignored");
        read_chk(1'b1, 1'b1, "R8", "still toggling after late command");
        issue(8'h08, 1'b0);
        read_chk(1'b1, 1'b0, "R9", "read while suspended");
        chk(window_bit, 1'b1, "R9", "window while suspended");
        issue(8'h01, 1'b0);
        read_chk(1'b1, 1'b1, "R9", "read in suspend program");
        issue(8'h40, 1'b0);
        read_chk(1'b1, 1'b0, "R9", "read back in suspend");
        issue(8'h10, 1'b0);
        read_chk(1'b1, 1'b1, "R9", "read after resume");
        issue(8'h40, 1'b0);
        chk(window_bit, 1'b0, "R9", "window after erase done");
        read_chk(1'b1, 1'b0, "R9", "read after erase done");

        // R7: sector erase with every target protected
        issue(8'h02, 1'b1);
        wait_cyc(WN);
        chk(window_bit, 1'b1, "R7", "protected erase dummy running");
        read_chk(1'b1, 1'b1, "R7", "read in erase dummy");
        wait_cyc(ED + 2);
        chk(window_bit, 1'b0, "R7", "protected erase finished");

        // R10: overrun with simultaneous completion
        issue(8'h01, 1'b0);
        issue(8'hC0, 1'b0);
        chk(limit_bit, 1'b1, "R10", "limit after overrun");
        read_chk(1'b1, 1'b1, "R10", "toggling while failed");
        issue(8'h40, 1'b0);
        chk(limit_bit, 1'b1, "R10", "limit sticky");
        issue(8'h20, 1'b0);
        chk(limit_bit, 1'b0, "R11", "limit cleared by reset");
        read_chk(1'b1, 1'b0, "R11", "no toggle after reset");

        // R11: reset during an open window
        issue(8'h02, 1'b0);
        issue(8'h20, 1'b0);
        chk(window_bit, 1'b0, "R11", "window after reset");
        wait_cyc(WN + 2);
        chk(window_bit, 1'b0, "R11", "aborted window never closes");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule